// File: doc/BRIEF.md
# BCD Clock Calendar with Century Bit

This block keeps wall-clock time and calendar date in packed BCD. A once-per-second tick from an external prescaler moves it forward through seconds, minutes and 24-hour hours, then through day of week, day of month, month and two-digit year. Month lengths follow the calendar, with a 29th of February in every year whose value is a multiple of four. A century bit sits beside the hours field and can be set to flip each time the year rolls from 99 to 00.

The block also supervises the oscillator. A disable bit beside the seconds field stops all counting. A sticky stop flag records any change of the oscillator from running to stopped, including the state at power-up. Software writes each register through its own strobe with a shared data byte. All registers are visible in parallel on one packed output. A one-cycle pulse marks each minute boundary, so a neighbouring block can schedule per-minute work.

Register index i sits at `reg_out[8*i+7:8*i]` and is written by `wr_en[i]`. Index 0 holds the disable bit in bit 7 and seconds in bits 6:0. Index 1 holds minutes in bits 6:0. Index 2 holds the century enable in bit 7, the century bit in bit 6 and hours in bits 5:0. Index 3 holds the day of week in bits 2:0. Index 4 holds the date in bits 5:0. Index 5 holds the month in bits 4:0. Index 6 holds the year in bits 7:0. Index 7 holds the stop flag in bit 7. Every bit not listed here reads 0.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset, registers 0 to 7 read 00, 00, 00, 01, 01, 01, 00, 80 (hex): time 00:00:00, day 1, date 01, month 01, year 00, century enable and century bit at 0, disable bit at 0, and the stop flag set.
- R2: Each accepted tick moves seconds forward in BCD, so 09 is followed by 10. When seconds reach 59 they return to 00 and minutes move forward. Minutes wrap from 59 to 00 and move hours forward. Hours wrap from 23 to 00, and that wrap is midnight.
- R3: `min_pulse` is high for exactly one cycle: the cycle in which seconds first read 00 after wrapping from 59. It is low at all other times.
- R4: The day of week moves forward by one at midnight and goes from 7 back to 1.
- R5: At midnight the date goes back to 01 once it has reached the last day of its month, and the month then moves forward. Months 04, 06, 09 and 11 have 30 days, month 02 has 28 days, or 29 when the BCD year is a multiple of four (00 included), and every other month has 31. Month 12 wraps to 01 and moves the year forward, and year 99 wraps to 00.
- R6: When the year wraps from 99 to 00, the century bit (register 2 bit 6) toggles if the century enable (register 2 bit 7) is 1 and keeps its value if the enable is 0.
- R7: While the disable bit (register 0 bit 7) is 1, or while `osc_running` is 0, ticks are ignored and no time or date field changes.
- R8: The stop flag (register 7 bit 7) is set one cycle after the oscillator goes from running to not running, whether because of the disable bit or because of `osc_running`. It then stays set until register 7 is written with bit 7 at 0. Writing bit 7 at 1 leaves the flag unchanged.
- R9: A write replaces its field at the next clock edge and masks off the unused bits, which read 0. A tick that arrives in the same cycle as a write to any of registers 0 to 6 is dropped.
- R10: A field written with an out-of-range value still wraps at its limit. Seconds written as 7F read 00 after the next tick and carry into minutes. A date of 31 in a 30-day month returns to 01 at midnight and moves the month forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| osc_running | input | 1 | High while the oscillator runs |
| wr_en | input | 8 | Write strobe, one per register index |
| wr_data | input | 8 | Byte written to each strobed register |
| reg_out | output | 64 | All eight registers, index i at bits 8*i+7:8*i |
| min_pulse | output | 1 | One-cycle pulse at each minute boundary |

## Verification
A wrong carry between fields shows up at the ports at the first tick that crosses a field limit. The bench therefore preloads each boundary (59 seconds, 23:59:59, the last day of each month length, year 99) and checks the full register image one cycle after a single tick. A leap-year decode error only shows up on 28 or 29 February at midnight, so several years with different tens digits are run through that boundary. A stop flag that fails to stick, or a century bit that toggles when it should not, shows up in the next register read after the event. The assertions catch both conditions at the clock edge that follows the cause.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;
  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DOW  = 3;
  localparam int IDX_DATE = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;
  localparam int IDX_FLAG = 7;
  localparam int TIME_REGS = IDX_YEAR + 1;

  localparam logic [REG_W-1:0] SEC_LAST  = 8'h59;
  localparam logic [REG_W-1:0] MIN_LAST  = 8'h59;
  localparam logic [REG_W-1:0] HOUR_LAST = 8'h23;
  localparam logic [REG_W-1:0] DOW_LAST  = 8'h07;
  localparam logic [REG_W-1:0] MON_LAST  = 8'h12;
  localparam logic [REG_W-1:0] YEAR_LAST = 8'h99;
  localparam logic [REG_W-1:0] BCD_ONE   = 8'h01;

  typedef logic [REG_W-1:0] bcd_byte_t;

  // Two-digit BCD increment; a units digit at 9 or above carries.
  function automatic bcd_byte_t bcd_next(input bcd_byte_t v);
    if (v[3:0] >= 4'd9) bcd_next = {v[7:4] + 4'd1, 4'd0};
    else                bcd_next = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Multiple of four in BCD: even tens need units 0/4/8, odd tens need 2/6.
  function automatic logic bcd_leap(input bcd_byte_t y);
    if (y[4]) bcd_leap = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      bcd_leap = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic bcd_byte_t month_last_day(input bcd_byte_t m, input logic leap);
    case (m)
      8'h02:                      month_last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_last_day = 8'h30;
      default:                    month_last_day = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_time_chain.sv
module cal_time_chain
  import cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step,
  input  logic      wr_sec,
  input  logic      wr_min,
  input  logic      wr_hour,
  input  bcd_byte_t wr_data,
  output bcd_byte_t sec,
  output bcd_byte_t min,
  output bcd_byte_t hour,
  output logic      sec_wrap,
  output logic      min_wrap,
  output logic      day_step,
  output logic      min_pulse
);
  wire unused_wr_top = &{1'b0, wr_data[7]};

  assign sec_wrap = step && (sec >= SEC_LAST);
  assign min_wrap = sec_wrap && (min >= MIN_LAST);
  assign day_step = min_wrap && (hour >= HOUR_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec       <= '0;
      min       <= '0;
      hour      <= '0;
      min_pulse <= 1'b0;
    end else begin
      min_pulse <= sec_wrap;
      if (wr_sec)        sec <= {1'b0, wr_data[6:0]};
      else if (sec_wrap) sec <= '0;
      else if (step)     sec <= bcd_next(sec);

      if (wr_min)        min <= {1'b0, wr_data[6:0]};
      else if (min_wrap) min <= '0;
      else if (sec_wrap) min <= bcd_next(min);

      if (wr_hour)       hour <= {2'b0, wr_data[5:0]};
      else if (day_step) hour <= '0;
      else if (min_wrap) hour <= bcd_next(hour);
    end
  end
endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
  import cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      day_step,
  input  logic      wr_hour,
  input  logic      wr_dow,
  input  logic      wr_date,
  input  logic      wr_mon,
  input  logic      wr_year,
  input  bcd_byte_t wr_data,
  output bcd_byte_t dow,
  output bcd_byte_t date,
  output bcd_byte_t mon,
  output bcd_byte_t year,
  output logic      cen_en,
  output logic      cen,
  output logic      date_wrap,
  output logic      year_wrap
);
  bcd_byte_t last_day;
  logic      mon_wrap;

  assign last_day  = month_last_day(mon, bcd_leap(year));
  assign date_wrap = day_step && (date >= last_day);
  assign mon_wrap  = date_wrap && (mon >= MON_LAST);
  assign year_wrap = mon_wrap && (year >= YEAR_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow    <= BCD_ONE;
      date   <= BCD_ONE;
      mon    <= BCD_ONE;
      year   <= '0;
      cen_en <= 1'b0;
      cen    <= 1'b0;
    end else begin
      if (wr_dow)        dow <= {5'b0, wr_data[2:0]};
      else if (day_step) dow <= (dow >= DOW_LAST) ? BCD_ONE : dow + 8'd1;

      if (wr_date)        date <= {2'b0, wr_data[5:0]};
      else if (date_wrap) date <= BCD_ONE;
      else if (day_step)  date <= bcd_next(date);

      if (wr_mon)         mon <= {3'b0, wr_data[4:0]};
      else if (mon_wrap)  mon <= BCD_ONE;
      else if (date_wrap) mon <= bcd_next(mon);

      if (wr_year)        year <= wr_data;
      else if (year_wrap) year <= '0;
      else if (mon_wrap)  year <= bcd_next(year);

      if (wr_hour) begin
        cen_en <= wr_data[7];
        cen    <= wr_data[6];
      end else if (year_wrap && cen_en) begin
        cen <= ~cen;
      end
    end
  end
endmodule

// File: rtl/cal_osc_monitor.sv
module cal_osc_monitor
  import cal_pkg::*;
#(
  parameter logic FLAG_AT_RESET = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      osc_running,
  input  logic      wr_ctl,
  input  logic      wr_flag,
  input  bcd_byte_t wr_data,
  output logic      osc_dis,
  output logic      stop_flag,
  output logic      run_now,
  output logic      stop_edge
);
  logic run_q;
  wire unused_wr_low = &{1'b0, wr_data[6:0]};

  assign run_now   = osc_running && !osc_dis;
  assign stop_edge = run_q && !run_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_dis   <= 1'b0;
      run_q     <= 1'b0;
      stop_flag <= FLAG_AT_RESET;
    end else begin
      run_q <= run_now;
      if (wr_ctl) osc_dis <= wr_data[7];
      if (stop_edge)                  stop_flag <= 1'b1;
      else if (wr_flag && !wr_data[7]) stop_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import cal_pkg::*;
#(
  parameter logic FLAG_AT_RESET = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_1hz,
  input  logic                      osc_running,
  input  logic [NUM_REGS-1:0]       wr_en,
  input  logic [REG_W-1:0]          wr_data,
  output logic [NUM_REGS*REG_W-1:0] reg_out,
  output logic                      min_pulse
);
  bcd_byte_t sec, min, hour, dow, date, mon, year;
  logic      cen_en, cen, osc_dis, stop_flag;
  logic      time_wr, step, run_now, stop_edge;
  logic      sec_wrap, min_wrap, day_step, date_wrap, year_wrap;
  bcd_byte_t regs [NUM_REGS];

  assign time_wr = |wr_en[TIME_REGS-1:0];
  assign step    = tick_1hz && run_now && !time_wr;

  cal_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .step(step),
    .wr_sec(wr_en[IDX_SEC]), .wr_min(wr_en[IDX_MIN]), .wr_hour(wr_en[IDX_HOUR]),
    .wr_data(wr_data), .sec(sec), .min(min), .hour(hour),
    .sec_wrap(sec_wrap), .min_wrap(min_wrap), .day_step(day_step),
    .min_pulse(min_pulse)
  );

  cal_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .day_step(day_step),
    .wr_hour(wr_en[IDX_HOUR]), .wr_dow(wr_en[IDX_DOW]), .wr_date(wr_en[IDX_DATE]),
    .wr_mon(wr_en[IDX_MON]), .wr_year(wr_en[IDX_YEAR]), .wr_data(wr_data),
    .dow(dow), .date(date), .mon(mon), .year(year),
    .cen_en(cen_en), .cen(cen), .date_wrap(date_wrap), .year_wrap(year_wrap)
  );

  cal_osc_monitor #(.FLAG_AT_RESET(FLAG_AT_RESET)) u_osc (
    .clk(clk), .rst_n(rst_n), .osc_running(osc_running),
    .wr_ctl(wr_en[IDX_SEC]), .wr_flag(wr_en[IDX_FLAG]), .wr_data(wr_data),
    .osc_dis(osc_dis), .stop_flag(stop_flag), .run_now(run_now), .stop_edge(stop_edge)
  );

  always_comb begin
    regs[IDX_SEC]  = {osc_dis, sec[6:0]};
    regs[IDX_MIN]  = {1'b0, min[6:0]};
    regs[IDX_HOUR] = {cen_en, cen, hour[5:0]};
    regs[IDX_DOW]  = {5'b0, dow[2:0]};
    regs[IDX_DATE] = {2'b0, date[5:0]};
    regs[IDX_MON]  = {3'b0, mon[4:0]};
    regs[IDX_YEAR] = year;
    regs[IDX_FLAG] = {stop_flag, 7'b0};
  end

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_pack
    assign reg_out[gi*REG_W +: REG_W] = regs[gi];
  end

  wire unused_upper = &{1'b0, sec[7], min[7], hour[7:6], dow[7:3], date[7:6], mon[7:5]};
endmodule

// File: rtl/cal_checker.sv
module cal_checker
  import cal_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_REGS-1:0]       wr_en,
  input logic [REG_W-1:0]          wr_data,
  input logic [NUM_REGS*REG_W-1:0] reg_out,
  input logic                      min_pulse,
  input logic                      sec_wrap,
  input logic                      day_step,
  input logic                      date_wrap,
  input logic                      year_wrap,
  input logic                      stop_edge,
  input logic                      run_now
);
  logic [6:0] c_sec;
  logic [5:0] c_hour;
  logic [2:0] c_dow;
  logic [5:0] c_date;
  logic       c_cen_en, c_cen, c_flag;

  assign c_sec    = reg_out[6:0];
  assign c_hour   = reg_out[IDX_HOUR*REG_W +: 6];
  assign c_dow    = reg_out[IDX_DOW*REG_W +: 3];
  assign c_date   = reg_out[IDX_DATE*REG_W +: 6];
  assign c_cen_en = reg_out[IDX_HOUR*REG_W + 7];
  assign c_cen    = reg_out[IDX_HOUR*REG_W + 6];
  assign c_flag   = reg_out[IDX_FLAG*REG_W + 7];

  p_pulse_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    min_pulse |-> (c_sec == 7'h00));
  p_pulse_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |=> min_pulse);
  p_midnight_hour_r2: assert property (@(posedge clk) disable iff (!rst_n)
    day_step |=> (c_hour == 6'h00));
  p_dow_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && c_dow == 3'd7) |=> (c_dow == 3'd1));
  p_date_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    date_wrap |=> (c_date == 6'h01));
  p_century_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (year_wrap && c_cen_en) |=> (c_cen != $past(c_cen)));
  p_century_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (year_wrap && !c_cen_en) |=> (c_cen == $past(c_cen)));
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_now && wr_en[TIME_REGS-1:0] == '0) |=> $stable(reg_out[TIME_REGS*REG_W-1:0]));
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_edge |=> c_flag);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (c_flag && !(wr_en[IDX_FLAG] && !wr_data[7])) |=> c_flag);
  p_sec_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[IDX_SEC] |=> (c_sec == $past(wr_data[6:0])));

  wire unused_chk = &{1'b0, wr_en[NUM_REGS-1:TIME_REGS]};
endmodule

bind bcd_calendar_core cal_checker i_cal_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .reg_out(reg_out),
  .min_pulse(min_pulse), .sec_wrap(sec_wrap), .day_step(day_step),
  .date_wrap(date_wrap), .year_wrap(year_wrap), .stop_edge(stop_edge), .run_now(run_now)
);

// File: tb/test_bcd_calendar_core.sv
module test_bcd_calendar_core;
  logic        clk = 1'b0;
  logic        rst_n, tick_1hz, osc_running;
  logic [7:0]  wr_en, wr_data;
  logic [63:0] reg_out;
  logic        min_pulse;
  int          n_checks = 0;
  int          n_fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  bcd_calendar_core i_bcd_calendar_core (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_running(osc_running),
    .wr_en(wr_en), .wr_data(wr_data), .reg_out(reg_out), .min_pulse(min_pulse)
  );

  function automatic logic [7:0] rd(input int idx);
    return reg_out[8*idx +: 8];
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 8'(1 << idx);
    wr_data = d;
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic tick1();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                         input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                         input logic [7:0] yr);
    wr(0, s); wr(1, m); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, yr);
  endtask

  function automatic int bcd2int(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  task automatic t_reset();
    logic [7:0] exp [8] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h80};
    for (int i = 0; i < 8; i++) chk("R1", $sformatf("reg%0d after reset", i), rd(i), exp[i]);
    chk("R3", "min_pulse idle", {7'b0, min_pulse}, 8'h00);
  endtask

  task automatic t_flag_write();
    wr(7, 8'h80);
    chk("R8", "flag write 1 keeps set", rd(7), 8'h80);
    wr(7, 8'h00);
    chk("R8", "flag cleared by 0", rd(7), 8'h00);
    wr(7, 8'hFF);
    chk("R8", "flag write 1 no set", rd(7), 8'h00);
  endtask

  task automatic t_seconds();
    wr(0, 8'h09);
    tick1();
    chk("R2", "sec 09 to 10", rd(0), 8'h10);
    chk("R3", "no pulse mid-minute", {7'b0, min_pulse}, 8'h00);
    set_all(8'h59, 8'h14, 8'h05, 8'h03, 8'h12, 8'h06, 8'h30);
    tick1();
    chk("R2", "sec wrap", rd(0), 8'h00);
    chk("R2", "min carry", rd(1), 8'h15);
    chk("R3", "pulse on wrap", {7'b0, min_pulse}, 8'h01);
    @(negedge clk);
    chk("R3", "pulse one cycle", {7'b0, min_pulse}, 8'h00);
    wr(0, 8'h59); wr(1, 8'h59);
    tick1();
    chk("R2", "min wrap", rd(1), 8'h00);
    chk("R2", "hour carry", rd(2), 8'h06);
  endtask

  task automatic t_new_century(input logic cen_on, input logic cen_start);
    logic [7:0] exp_h;
    set_all(8'h59, 8'h59, {cen_on, cen_start, 6'h23}, 8'h07, 8'h31, 8'h12, 8'h99);
    tick1();
    exp_h = {cen_on, cen_start ^ cen_on, 6'h00};
    chk("R6", $sformatf("century en=%0d start=%0d", cen_on, cen_start), rd(2), exp_h);
    chk("R4", "dow 7 to 1", rd(3), 8'h01);
    chk("R5", "date new year", rd(4), 8'h01);
    chk("R5", "month 12 to 01", rd(5), 8'h01);
    chk("R5", "year 99 to 00", rd(6), 8'h00);
    chk("R2", "midnight time", rd(0) | rd(1), 8'h00);
  endtask

  task automatic t_dow_step();
    set_all(8'h59, 8'h59, 8'h23, 8'h04, 8'h10, 8'h03, 8'h11);
    tick1();
    chk("R4", "dow 4 to 5", rd(3), 8'h05);
    chk("R5", "date 10 to 11", rd(4), 8'h11);
  endtask

  task automatic t_feb();
    logic [7:0] years [7] = '{8'h00, 8'h04, 8'h10, 8'h23, 8'h24, 8'h96, 8'h98};
    foreach (years[k]) begin
      bit leap = (bcd2int(years[k]) % 4) == 0;
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, years[k]);
      tick1();
      chk("R5", $sformatf("feb28 year %h date", years[k]), rd(4), leap ? 8'h29 : 8'h01);
      chk("R5", $sformatf("feb28 year %h month", years[k]), rd(5), leap ? 8'h02 : 8'h03);
    end
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    tick1();
    chk("R5", "feb29 leap ends", rd(5), 8'h03);
  endtask

  task automatic t_month_len();
    logic [7:0] months [12] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
                               8'h07, 8'h08, 8'h09, 8'h10, 8'h11, 8'h12};
    foreach (months[k]) begin
      int mi = bcd2int(months[k]);
      bit short = (mi == 4) || (mi == 6) || (mi == 9) || (mi == 11);
      if (mi == 2) continue;
      set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, months[k], 8'h21);
      tick1();
      chk("R5", $sformatf("day 30 of month %h", months[k]), rd(4), short ? 8'h01 : 8'h31);
    end
  endtask

  task automatic t_osc_disable();
    wr(7, 8'h00);
    wr(0, 8'h90);
    @(negedge clk);
    chk("R8", "flag set by disable", rd(7), 8'h80);
    tick1();
    chk("R7", "disabled ignores tick", rd(0), 8'h90);
    wr(0, 8'h10);
    tick1();
    chk("R7", "enabled counts", rd(0), 8'h11);
    chk("R8", "flag sticks", rd(7), 8'h80);
    wr(7, 8'h00);
  endtask

  task automatic t_osc_stopped();
    @(negedge clk);
    osc_running = 1'b0;
    @(negedge clk);
    chk("R8", "flag set by stop", rd(7), 8'h80);
    tick1();
    chk("R7", "stopped ignores tick", rd(0), 8'h11);
    @(negedge clk);
    osc_running = 1'b1;
    wr(7, 8'h00);
    tick1();
    chk("R7", "restart counts", rd(0), 8'h12);
    chk("R8", "flag stays clear on restart", rd(7), 8'h00);
  endtask

  task automatic t_write_wins();
    wr(0, 8'h05);
    @(negedge clk);
    tick_1hz = 1'b1;
    wr_en = 8'h02;
    wr_data = 8'h30;
    @(negedge clk);
    tick_1hz = 1'b0;
    wr_en = '0;
    chk("R9", "tick dropped on write", rd(0), 8'h05);
    chk("R9", "written minutes", rd(1), 8'h30);
    wr(1, 8'hFF);
    chk("R9", "minute mask", rd(1), 8'h7F);
    wr(3, 8'hFF);
    chk("R9", "dow mask", rd(3), 8'h07);
  endtask

  task automatic t_out_of_range();
    wr(1, 8'h10);
    wr(0, 8'h7F);
    tick1();
    chk("R10", "sec 7F wraps", rd(0), 8'h00);
    chk("R10", "sec 7F carries", rd(1), 8'h11);
    set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h04, 8'h21);
    tick1();
    chk("R10", "april 31 date", rd(4), 8'h01);
    chk("R10", "april 31 month", rd(5), 8'h05);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL all: watchdog actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    tick_1hz = 1'b0;
    osc_running = 1'b1;
    wr_en = '0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flag_write();
    t_seconds();
    t_new_century(1'b1, 1'b0);
    t_new_century(1'b1, 1'b1);
    t_new_century(1'b0, 1'b1);
    t_new_century(1'b0, 1'b0);
    t_dow_step();
    t_feb();
    t_month_len();
    wr(0, 8'h10);
    t_osc_disable();
    t_osc_stopped();
    t_write_wins();
    t_out_of_range();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule